// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller

This block is a general-purpose I/O port of sixteen pins, controlled through a simple single-cycle register bus. It holds a function-enable mask, a data register, a direction mask, an input-buffer enable mask and a 32-bit pin-multiplexing word. The data register can be written directly or through write-one-to-set and write-one-to-clear aliases. Direction has no direct write path and is changed only through its own set and clear aliases. Every access is checked for its width, and a rejected access is reported with an error code.

Each pin has an output value and an output enable. The output enable follows the direction bit. An output value is refreshed only by writes that can change what a pin drives, and only on pins whose input buffer is off. Each pin is also sampled every cycle. Its level is copied into the data register only while the pin is an input, its input buffer is on and its function bit is set.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, all state is zero: pin_oe and pin_out are 0, rsp_valid is 0, and every register reads back 0.
- R2: Each cycle with req_valid high produces rsp_valid high on the next cycle, and only then. The byte offsets are 0x00 function enable, 0x04 data, 0x08 data-set, 0x0C data-clear, 0x10 direction-set, 0x14 direction-clear, 0x18 input enable and 0x1C mux. req_size encodes the width as 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Write responses return zero read data.
- R3: The mux offset accepts only size 2. Every other offset accepts only size 1. Any other width gives rsp_err_code 1.
- R4: An offset outside the eight listed ones, whether unaligned or above 0x1C, gives rsp_err_code 2 when the size is 1. With any other size it gives code 1, because the width error takes priority.
- R5: An access with a nonzero error code changes no state, and its rsp_rdata is 0.
- R6: A data-set write ORs the low 16 bits of the write data into data. A data-clear write clears the data bits written as 1. Reads of data, data-set and data-clear all return the data value.
- R7: Writing ones to direction-set sets those direction bits, and writing ones to direction-clear clears them. Reads of either offset return the direction value. pin_oe equals the direction value, and it changes only after a write to one of these two offsets.
- R8: Writes to function enable, data and input enable store the low 16 bits of the write data. A mux write stores all 32 bits. Reads return the stored value, zero-extended.
- R9: After an accepted write to data, data-set, data-clear or direction-set, every pin whose input-enable bit is 0 outputs the data bit on pin_out in the next cycle. Pins whose input-enable bit is 1 hold their previous output.
- R10: On every cycle, a data bit takes the level of pin_in when that pin's direction bit is 0, its input-enable bit is 1 and its function bit is 1. On other pins the level is ignored. An accepted write to data, data-set or data-clear in the same cycle takes precedence.
- R11: pin_out does not change on writes to function enable, direction-clear, input enable or mux, nor on a data change caused by sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_size | input | 2 | Access width code (0: 8, 1: 16, 2: 32 bits) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data, zero on errors and writes |
| rsp_err_code | output | 2 | 0 ok, 1 wrong width, 2 unmapped offset |
| pin_in | input | 16 | Incoming pin levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables (direction) |

## Verification
The checker watches, on every cycle, the timing of requests and responses, the error codes for a wrong mux width and for width-before-unmapped priority, and the zero read data on errors. It also checks that pin_oe and pin_out move only after the writes allowed to move them. The register contents cannot be checked that way. Set and clear arithmetic, the qualification of input sampling, the per-pin refresh that depends on input enable, and the absence of a refresh after sampling are all shown only by the bench's scenarios.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    SEL_FUNC  = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_DSET  = 3'd2,
    SEL_DCLR  = 3'd3,
    SEL_OSET  = 3'd4,
    SEL_OCLR  = 3'd5,
    SEL_IBUF  = 3'd6,
    SEL_MUX   = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACC_OK       = 2'd0,
    ACC_WIDTH    = 2'd1,
    ACC_UNMAPPED = 2'd2
  } acc_err_e;

  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output reg_sel_e          sel,
  output acc_err_e          err
);
  localparam int REG_SPAN_LOG2 = 5;

  logic in_range;
  logic is_mux;
  logic width_ok;

  always_comb begin
    in_range = (addr[1:0] == 2'b00) && ((addr >> REG_SPAN_LOG2) == '0);
    sel      = reg_sel_e'(addr[4:2]);
    is_mux   = in_range && (sel == SEL_MUX);
    width_ok = is_mux ? (size == SIZE_WORD) : (size == SIZE_HALF);
    if (!width_ok)      err = ACC_WIDTH;
    else if (!in_range) err = ACC_UNMAPPED;
    else                err = ACC_OK;
  end
endmodule

// File: rtl/gpio_port_pins.sv
module gpio_port_pins #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] inen,
  input  logic [NPIN-1:0] fer,
  input  logic [NPIN-1:0] data_nxt,
  input  logic            refresh,
  output logic [NPIN-1:0] sample_mask,
  output logic [NPIN-1:0] pin_out
);
  logic [NPIN-1:0] out_q;
  logic [NPIN-1:0] out_nxt;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      sample_mask[i] = !dir[i] && inen[i] && fer[i];
      out_nxt[i]     = inen[i] ? out_q[i] : data_nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (refresh) out_q <= out_nxt;
  end

  assign pin_out = out_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NPIN   = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic [1:0]        rsp_err_code,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  reg_sel_e sel;
  acc_err_e err;

  gpio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .sel  (sel),
    .err  (err)
  );

  logic [NPIN-1:0]  fer_q, data_q, dir_q, inen_q;
  logic [BUS_W-1:0] mux_q;
  logic [NPIN-1:0]  fer_nxt, data_nxt, dir_nxt, inen_nxt;
  logic [NPIN-1:0]  sample_mask;
  logic [NPIN-1:0]  wval;
  logic             acc_ok, wr_en, rd_en, refresh;
  logic             fer_en, dir_en, inen_en, mux_en;
  logic [BUS_W-1:0] rdata_nxt;

  gpio_port_pins #(.NPIN(NPIN)) u_pins (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .dir         (dir_q),
    .inen        (inen_q),
    .fer         (fer_q),
    .data_nxt    (data_nxt),
    .refresh     (refresh),
    .sample_mask (sample_mask),
    .pin_out     (pin_out)
  );

  always_comb begin
    acc_ok  = req_valid && (err == ACC_OK);
    wr_en   = acc_ok && req_write;
    rd_en   = acc_ok && !req_write;
    wval    = req_wdata[NPIN-1:0];

    fer_en  = wr_en && (sel == SEL_FUNC);
    inen_en = wr_en && (sel == SEL_IBUF);
    mux_en  = wr_en && (sel == SEL_MUX);
    dir_en  = wr_en && ((sel == SEL_OSET) || (sel == SEL_OCLR));
    refresh = wr_en && ((sel == SEL_DATA) || (sel == SEL_DSET) ||
                        (sel == SEL_DCLR) || (sel == SEL_OSET));

    fer_nxt  = wval;
    inen_nxt = wval;
    dir_nxt  = (sel == SEL_OSET) ? (dir_q | wval) : (dir_q & ~wval);

    data_nxt = (data_q & ~sample_mask) | (pin_in & sample_mask);
    if (wr_en) begin
      case (sel)
        SEL_DATA: data_nxt = wval;
        SEL_DSET: data_nxt = data_q | wval;
        SEL_DCLR: data_nxt = data_q & ~wval;
        default:  ;
      endcase
    end

    rdata_nxt = '0;
    if (rd_en) begin
      case (sel)
        SEL_FUNC:                     rdata_nxt = BUS_W'(fer_q);
        SEL_DATA, SEL_DSET, SEL_DCLR: rdata_nxt = BUS_W'(data_q);
        SEL_OSET, SEL_OCLR:           rdata_nxt = BUS_W'(dir_q);
        SEL_IBUF:                     rdata_nxt = BUS_W'(inen_q);
        default:                      rdata_nxt = mux_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fer_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      inen_q <= '0;
      mux_q  <= '0;
    end else begin
      if (fer_en)  fer_q  <= fer_nxt;
      if (inen_en) inen_q <= inen_nxt;
      if (dir_en)  dir_q  <= dir_nxt;
      if (mux_en)  mux_q  <= req_wdata;
      data_q <= data_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_err_code <= 2'd0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_rdata    <= rdata_nxt;
      rsp_err_code <= req_valid ? err : ACC_OK;
    end
  end

  assign pin_oe = dir_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int NPIN   = 16,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic [BUS_W-1:0]  rsp_rdata,
  input logic [1:0]        rsp_err_code,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe
);
  logic dir_wr, out_wr, high_addr;
  assign dir_wr    = req_valid && req_write &&
                     (req_addr == ADDR_W'(8'h10) || req_addr == ADDR_W'(8'h14));
  assign out_wr    = req_valid && req_write &&
                     (req_addr == ADDR_W'(8'h04) || req_addr == ADDR_W'(8'h08) ||
                      req_addr == ADDR_W'(8'h0C) || req_addr == ADDR_W'(8'h10));
  assign high_addr = (req_addr >> 5) != '0;

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  mux_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == ADDR_W'(8'h1C) && req_size != 2'd2) |=> (rsp_err_code == 2'd1));
  // R4
  width_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && high_addr && req_size != 2'd1) |=> (rsp_err_code == 2'd1));
  // R5
  err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err_code != 2'd0) |-> (rsp_rdata == '0));
  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe));
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr |=> $stable(pin_out));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.ADDR_W(ADDR_W), .NPIN(NPIN), .BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_size     (req_size),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .rsp_err_code (rsp_err_code),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [5:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_err_code;
  logic [15:0] pin_in, pin_out, pin_oe;

  int tests = 0;
  int fails = 0;
  logic [31:0] rd;
  logic [1:0]  ec;

  always #5 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err_code(rsp_err_code),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [5:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [1:0]  ecode;
    logic [31:0] erd;
  } vec_t;

  localparam int NVEC = 26;
  localparam vec_t VEC [NVEC] = '{
    '{4'd8, 1'b1, 6'h00, 2'd1, 32'h0000_00FF, 2'd0, 32'h0},
    '{4'd8, 1'b0, 6'h00, 2'd1, 32'h0,         2'd0, 32'h0000_00FF},
    '{4'd8, 1'b1, 6'h04, 2'd1, 32'h0000_1234, 2'd0, 32'h0},
    '{4'd8, 1'b0, 6'h04, 2'd1, 32'h0,         2'd0, 32'h0000_1234},
    '{4'd6, 1'b1, 6'h08, 2'd1, 32'h0000_0F00, 2'd0, 32'h0},
    '{4'd6, 1'b0, 6'h08, 2'd1, 32'h0,         2'd0, 32'h0000_1F34},
    '{4'd6, 1'b1, 6'h0C, 2'd1, 32'h0000_0034, 2'd0, 32'h0},
    '{4'd6, 1'b0, 6'h0C, 2'd1, 32'h0,         2'd0, 32'h0000_1F00},
    '{4'd7, 1'b1, 6'h10, 2'd1, 32'h0000_00F0, 2'd0, 32'h0},
    '{4'd7, 1'b0, 6'h14, 2'd1, 32'h0,         2'd0, 32'h0000_00F0},
    '{4'd7, 1'b1, 6'h14, 2'd1, 32'h0000_0030, 2'd0, 32'h0},
    '{4'd7, 1'b0, 6'h10, 2'd1, 32'h0,         2'd0, 32'h0000_00C0},
    '{4'd8, 1'b1, 6'h1C, 2'd2, 32'hDEAD_BEEF, 2'd0, 32'h0},
    '{4'd8, 1'b0, 6'h1C, 2'd2, 32'h0,         2'd0, 32'hDEAD_BEEF},
    '{4'd3, 1'b1, 6'h1C, 2'd1, 32'h0000_1111, 2'd1, 32'h0},
    '{4'd5, 1'b0, 6'h1C, 2'd2, 32'h0,         2'd0, 32'hDEAD_BEEF},
    '{4'd3, 1'b0, 6'h04, 2'd2, 32'h0,         2'd1, 32'h0},
    '{4'd4, 1'b1, 6'h20, 2'd1, 32'h0000_FFFF, 2'd2, 32'h0},
    '{4'd4, 1'b0, 6'h22, 2'd1, 32'h0,         2'd2, 32'h0},
    '{4'd4, 1'b0, 6'h20, 2'd0, 32'h0,         2'd1, 32'h0},
    '{4'd3, 1'b1, 6'h04, 2'd0, 32'h0000_FFFF, 2'd1, 32'h0},
    '{4'd5, 1'b0, 6'h04, 2'd1, 32'h0,         2'd0, 32'h0000_1F00},
    '{4'd8, 1'b1, 6'h18, 2'd1, 32'hFFFF_1111, 2'd0, 32'h0},
    '{4'd8, 1'b0, 6'h18, 2'd1, 32'h0,         2'd0, 32'h0000_1111},
    '{4'd4, 1'b1, 6'h02, 2'd1, 32'h0,         2'd2, 32'h0},
    '{4'd4, 1'b0, 6'h38, 2'd1, 32'h0,         2'd2, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [5:0] a, input logic [1:0] s,
                     input logic [31:0] d, output logic [31:0] r, output logic [1:0] e);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    if (rsp_valid !== 1'b1) begin
      tests++; fails++;
      $display("FAIL R2 rsp_valid actual=%b expected=1", rsp_valid);
    end
    r = rsp_rdata;
    e = rsp_err_code;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    req_valid = 0; req_write = 0; req_addr = '0; req_size = '0; req_wdata = '0;
    pin_in = '0;
    do_reset();

    // R1: reset state
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    bus(0, 6'h00, 1, 0, rd, ec); check("R1 func reads 0", rd, 32'h0);
    bus(0, 6'h04, 1, 0, rd, ec); check("R1 data reads 0", rd, 32'h0);
    bus(0, 6'h1C, 2, 0, rd, ec); check("R1 mux reads 0", rd, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      bus(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].wdata, rd, ec);
      check($sformatf("R%0d vec%0d code", VEC[i].req, i), 32'(ec), 32'(VEC[i].ecode));
      check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rd, VEC[i].erd);
    end

    // R5: errored direction-set write leaves pin_oe alone
    bus(1, 6'h10, 2, 32'hFFFF, rd, ec);
    check("R5 dir untouched by bad width", 32'(pin_oe), 32'h00C0);
    // R7: pin_oe follows direction
    bus(1, 6'h10, 1, 32'h0300, rd, ec);
    check("R7 pin_oe after set", 32'(pin_oe), 32'h03C0);

    // R9: refresh depends on input enable
    do_reset();
    bus(1, 6'h04, 1, 32'hA5A5, rd, ec);
    check("R9 data write drives out", 32'(pin_out), 32'hA5A5);
    check("R7 oe stays 0", 32'(pin_oe), 32'h0);
    bus(1, 6'h10, 1, 32'h00FF, rd, ec);
    check("R7 oe after dir set", 32'(pin_oe), 32'h00FF);
    bus(1, 6'h18, 1, 32'h00F0, rd, ec);
    bus(1, 6'h0C, 1, 32'h00FF, rd, ec);
    check("R9 masked pins hold", 32'(pin_out), 32'hA5A0);

    // R10 and R11: sampled level lands in data, not on pin_out
    do_reset();
    bus(1, 6'h04, 1, 32'h5000, rd, ec);
    bus(1, 6'h00, 1, 32'h00FF, rd, ec);
    bus(1, 6'h18, 1, 32'h0F0F, rd, ec);
    bus(1, 6'h10, 1, 32'h0003, rd, ec);
    pin_in = 16'hFFFF;
    repeat (2) @(negedge clk);
    bus(0, 6'h04, 1, 0, rd, ec);
    check("R10 only qualified pins sample", rd, 32'h500C);
    check("R11 sampling leaves pin_out", 32'(pin_out), 32'h5000);
    bus(1, 6'h18, 1, 32'h0000, rd, ec);
    check("R11 input-enable write no refresh", 32'(pin_out), 32'h5000);
    bus(1, 6'h14, 1, 32'h0000, rd, ec);
    check("R11 dir-clear write no refresh", 32'(pin_out), 32'h5000);
    bus(1, 6'h10, 1, 32'h0000, rd, ec);
    check("R9 dir-set write refreshes", 32'(pin_out), 32'h500C);
    bus(1, 6'h18, 1, 32'h0F0F, rd, ec);
    pin_in = 16'h0000;
    repeat (2) @(negedge clk);
    bus(0, 6'h08, 1, 0, rd, ec);
    check("R10 low level sampled", rd, 32'h5000);
    bus(1, 6'h00, 1, 32'h0000, rd, ec);
    pin_in = 16'hFFFF;
    repeat (2) @(negedge clk);
    bus(0, 6'h0C, 1, 0, rd, ec);
    check("R10 ignored without function bit", rd, 32'h5000);

    finish_run();
  end
endmodule